// File: doc/BRIEF.md
# Multi-Rate Nibble Lane Serializer/Deserializer

This block is the digital datapath of one serial lane. A 4-bit parallel word moves in each direction at a fixed word rate of one word per four clock cycles. The serial line runs at one of three rates, chosen by a 2-bit rate code:

- In full rate, all four word bits are put on the line.
- In half rate, two bits are sent and each is held for two clocks.
- In feed-through, one bit is sent and held for the whole word.

Because the parallel side never changes speed, the transmitter ignores unused nibble lanes at the lower rates. The receiver fills the unused output lanes with copies of the bits it did recover.

The clock runs at the full line bit rate and stands in for the analog bit clock. A free-running 2-bit phase counter defines the word boundary, and no framing search is done. The receive alignment is therefore whatever phase the counter held when reset was released. The transmit side reports when it takes a word. The receive side pulses a valid flag when a word is presented. A lock flag drops for a fixed number of word periods after reset and after every change of the effective rate.

Top module: `nib_serdes_lane`

## Requirements
- R1: During reset all outputs are 0. Afterwards `tx_take` is high for one cycle in every four. The first pulse is in the third cycle after the cycle in which reset is released. The nibble is captured at the clock edge that ends a `tx_take` cycle.
- R2: Codes 00 and 11 select full rate. Word bit k (LSB = bit 0) drives `tx_serial` in cycle k (0..3) of the following word period.
- R3: Code 10 selects half rate. Bit 0 drives `tx_serial` in cycles 0–1 and bit 2 in cycles 2–3. Bits 1 and 3 have no effect.
- R4: Code 01 selects feed-through. Bit 0 drives `tx_serial` for all four cycles, and bits 1–3 have no effect.
- R5: In full rate the receiver samples `rx_serial` at the clock edges of cycles 0..3 into bits 0..3. The assembled nibble appears on `rx_nibble` with `rx_valid` high in the cycle after the word ends. It holds until the next `rx_valid`.
- R6: In half rate the receiver samples in cycles 0 and 2 and outputs {s2,s2,s0,s0}, so bit 1 copies bit 0 and bit 3 copies bit 2.
- R7: In feed-through the sample from cycle 0 drives all four `rx_nibble` bits.
- R8: No framing: word alignment is fixed by the reset phase. With `rx_serial` tied to `tx_serial`, each word comes back on `rx_nibble` one word period after the one in which it was sent, filtered by R3/R4 and replicated by R6/R7.
- R9: `rate_mode` is sampled only at the word capture edge. A change inside a word period leaves that word's serial bits unchanged. The reset rate is full rate (code 11).
- R10: `locked` is low for exactly LOCK_WORDS word periods after reset and after any capture edge that changes the effective rate. Switching between codes 00 and 11 does not lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_mode | input | 2 | Rate code: 00/11 full, 10 half, 01 feed-through |
| tx_nibble | input | 4 | Parallel transmit word |
| tx_take | output | 1 | High in the cycle whose closing edge captures `tx_nibble` |
| tx_serial | output | 1 | Serial transmit bit |
| rx_serial | input | 1 | Serial receive bit |
| rx_nibble | output | 4 | Parallel receive word |
| rx_valid | output | 1 | One-cycle pulse when `rx_nibble` is updated |
| locked | output | 1 | High when the lane is settled at its current rate |

## Verification
The bench ties the serial output back to the serial input. In one capture edge, the receiver assembles the previous word, including a full-rate bit 3 taken live from the line, while the transmitter loads a new word and a new rate. The bench changes the rate code at exactly that boundary during sweeps of all 16 nibbles under every code. It judges each returned word against the mode of the word that carried it, not the mode of the word now being sent. A second collision falls on the lock counter: a rate change at the same edge as a word boundary must restart the count rather than decrement it. The bench counts the low cycles of `locked` after such a change and compares them with four times LOCK_WORDS.

// File: rtl/nib_serdes_pkg.sv
package nib_serdes_pkg;

    localparam int NIB  = 4;
    localparam int PH_W = $clog2(NIB);

    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,
        RATE_HALF = 2'd1,
        RATE_FEED = 2'd2
    } rate_e;

    // Pin code to effective rate; 00 and 11 are both full rate
    function automatic rate_e decode_rate(input logic [1:0] code);
        case (code)
            2'b10:   return RATE_HALF;
            2'b01:   return RATE_FEED;
            default: return RATE_FULL;
        endcase
    endfunction

    // Serial bit for a given phase of the word period
    function automatic logic tx_pick(input logic [NIB-1:0] word,
                                     input rate_e rate,
                                     input logic [PH_W-1:0] ph);
        case (rate)
            RATE_HALF: return word[{ph[PH_W-1], 1'b0}];
            RATE_FEED: return word[0];
            default:   return word[ph];
        endcase
    endfunction

    // Assemble a received nibble; live is the bit on the line in the last phase
    function automatic logic [NIB-1:0] rx_build(input logic [NIB-2:0] acc,
                                                input logic live,
                                                input rate_e rate);
        case (rate)
            RATE_HALF: return {acc[2], acc[2], acc[0], acc[0]};
            RATE_FEED: return {NIB{acc[0]}};
            default:   return {live, acc};
        endcase
    endfunction

endpackage

// File: rtl/nib_serdes_phase.sv
module nib_serdes_phase
    import nib_serdes_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            word_end
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB - 1);

    always_ff @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
    end

    assign word_end = (ph == PH_LAST);
endmodule

// File: rtl/nib_serdes_ser.sv
module nib_serdes_ser
    import nib_serdes_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] ph,
    input  logic            word_end,
    input  rate_e           rate_new,
    input  logic [NIB-1:0]  tx_nibble,
    output rate_e           rate_q,
    output logic            tx_serial
);
    logic [NIB-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rate_q <= RATE_FULL;
        end else if (word_end) begin
            word_q <= tx_nibble;
            rate_q <= rate_new;
        end
    end

    assign tx_serial = tx_pick(word_q, rate_q, ph);
endmodule

// File: rtl/nib_serdes_deser.sv
module nib_serdes_deser
    import nib_serdes_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] ph,
    input  logic            word_end,
    input  rate_e           rate_q,
    input  logic            rx_serial,
    output logic [NIB-1:0]  rx_nibble,
    output logic            rx_valid
);
    logic [NIB-2:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            for (int i = 0; i < NIB - 1; i++) begin
                if (ph == PH_W'(i)) acc[i] <= rx_serial;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_nibble <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= word_end;
            if (word_end) rx_nibble <= rx_build(acc, rx_serial, rate_q);
        end
    end
endmodule

// File: rtl/nib_serdes_lock.sv
module nib_serdes_lock
    import nib_serdes_pkg::*;
#(
    parameter int LOCK_WORDS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  word_end,
    input  rate_e rate_q,
    input  rate_e rate_new,
    output logic  locked
);
    localparam int CW = $clog2(LOCK_WORDS + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(LOCK_WORDS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_INIT;
        end else if (word_end) begin
            if (rate_new != rate_q) cnt <= CNT_INIT;
            else if (cnt != '0)     cnt <= cnt - CW'(1);
        end
    end

    assign locked = (cnt == '0);
endmodule

// File: rtl/nib_serdes_lane.sv
module nib_serdes_lane
    import nib_serdes_pkg::*;
#(
    parameter int LOCK_WORDS = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     rate_mode,
    input  logic [NIB-1:0] tx_nibble,
    output logic           tx_take,
    output logic           tx_serial,
    input  logic           rx_serial,
    output logic [NIB-1:0] rx_nibble,
    output logic           rx_valid,
    output logic           locked
);
    logic [PH_W-1:0] ph;
    logic            word_end;
    rate_e           rate_new;
    rate_e           rate_q;

    assign rate_new = decode_rate(rate_mode);
    assign tx_take  = word_end;

    nib_serdes_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .word_end (word_end)
    );

    nib_serdes_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .word_end  (word_end),
        .rate_new  (rate_new),
        .tx_nibble (tx_nibble),
        .rate_q    (rate_q),
        .tx_serial (tx_serial)
    );

    nib_serdes_deser u_deser (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .word_end  (word_end),
        .rate_q    (rate_q),
        .rx_serial (rx_serial),
        .rx_nibble (rx_nibble),
        .rx_valid  (rx_valid)
    );

    nib_serdes_lock #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .word_end (word_end),
        .rate_q   (rate_q),
        .rate_new (rate_new),
        .locked   (locked)
    );
endmodule

// File: rtl/nib_serdes_lane_chk.sv
module nib_serdes_lane_chk
    import nib_serdes_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [PH_W-1:0] ph,
    input rate_e           rate_q,
    input logic            tx_take,
    input logic            tx_serial,
    input logic [NIB-1:0]  rx_nibble,
    input logic            rx_valid,
    input logic            locked
);
    // R1: capture strobe never lasts two cycles
    assert_take_single_R1: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take);

    // R3: half rate holds each line bit for two cycles
    assert_half_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rate_q == RATE_HALF && ph[0] == 1'b0) |=> $stable(tx_serial));

    // R4: feed-through holds the line bit for the whole word
    assert_feed_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rate_q == RATE_FEED && ph != PH_W'(NIB - 1)) |=> $stable(tx_serial));

    // R5: receive word only moves with the valid pulse
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_nibble));

    // R6: half-rate words carry copied lanes
    assert_half_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rate_q) == RATE_HALF) |->
            (rx_nibble[1] == rx_nibble[0] && rx_nibble[3] == rx_nibble[2]));

    // R7: feed-through words are all one value
    assert_feed_copy_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rate_q) == RATE_FEED) |->
            (rx_nibble == {NIB{rx_nibble[0]}}));

    // R10: lock is lost only at a word boundary
    assert_lock_edge_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(tx_take));
endmodule

bind nib_serdes_lane nib_serdes_lane_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .rate_q    (rate_q),
    .tx_take   (tx_take),
    .tx_serial (tx_serial),
    .rx_nibble (rx_nibble),
    .rx_valid  (rx_valid),
    .locked    (locked)
);

// File: tb/nib_serdes_lane_tb.sv
module nib_serdes_lane_tb;
    localparam int L = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_mode = 2'b11;
    logic [3:0] tx_nibble = 4'h0;
    logic       loop_en = 1'b1;
    logic       drv_bit = 1'b0;
    logic       rx_serial;
    logic       tx_take, tx_serial, rx_valid, locked;
    logic [3:0] rx_nibble;

    int n_checks = 0;
    int n_fail = 0;
    int low_cnt = 0;
    logic       prev_valid = 1'b0;
    logic [3:0] prev_exp = 4'h0;
    string      prev_tag = "R8";

    assign rx_serial = loop_en ? tx_serial : drv_bit;

    always #5 clk = ~clk;

    nib_serdes_lane #(.LOCK_WORDS(L)) u_dut (
        .clk(clk), .rst(rst), .rate_mode(rate_mode), .tx_nibble(tx_nibble),
        .tx_take(tx_take), .tx_serial(tx_serial), .rx_serial(rx_serial),
        .rx_nibble(rx_nibble), .rx_valid(rx_valid), .locked(locked)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_tx(input logic [1:0] code, input logic [3:0] n, input int k);
        if (code == 2'b10) return n[(k / 2) * 2];
        if (code == 2'b01) return n[0];
        return n[k];
    endfunction

    function automatic logic [3:0] exp_rx(input logic [1:0] code, input logic [3:0] n);
        if (code == 2'b10) return 4'(n[0] * 3 + n[2] * 12);
        if (code == 2'b01) return n[0] ? 4'hF : 4'h0;
        return n;
    endfunction

    function automatic string tx_tag(input logic [1:0] code);
        if (code == 2'b10) return "R3";
        if (code == 2'b01) return "R4";
        return "R2";
    endfunction

    function automatic string rx_tag(input logic [1:0] code, input logic lb);
        if (lb) return "R8";
        if (code == 2'b10) return "R6";
        if (code == 2'b01) return "R7";
        return "R5";
    endfunction

    // Entered at the negedge of the last cycle of a word (tx_take high).
    // lb=1: line looped back; lb=0: receive pattern driven from n.
    task automatic word(input logic [1:0] code, input logic [3:0] n, input logic lb);
        rate_mode = code;
        tx_nibble = n;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                loop_en = lb;
                if (prev_valid) begin
                    chk({prev_tag, " valid"}, {3'b0, rx_valid}, 4'h1);
                    chk(prev_tag, rx_nibble, prev_exp);
                end
            end
            drv_bit = n[k];
            if (!locked) low_cnt++;
            chk(tx_tag(code), {3'b0, tx_serial}, {3'b0, exp_tx(code, n, k)});
        end
        chk("R1 take", {3'b0, tx_take}, 4'h1);
        prev_exp   = exp_rx(code, n);
        prev_valid = 1'b1;
        prev_tag   = rx_tag(code, lb);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] codes [4];
        int cnt;
        codes[0] = 2'b11; codes[1] = 2'b00; codes[2] = 2'b10; codes[3] = 2'b01;

        // R1 / R9 / R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 tx_serial", {3'b0, tx_serial}, 4'h0);
        chk("R1 rx_nibble", rx_nibble, 4'h0);
        chk("R1 rx_valid", {3'b0, rx_valid}, 4'h0);
        chk("R1 locked", {3'b0, locked}, 4'h0);
        rst = 1'b0;
        cnt = 1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R1 first take", {3'b0, tx_take}, {3'b0, i == 3});
            if (!locked) cnt++;
        end
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (locked) break;
            cnt++;
        end
        chk("R10 reset lock", 4'(cnt), 4'(4 * L));
        repeat (3) @(negedge clk);
        chk("R1 period", {3'b0, tx_take}, 4'h1);

        // R2, R3, R4, R8: exhaustive loopback sweep over every code
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 16; v++)
                word(codes[c], 4'(v), 1'b1);

        // R5, R6, R7: exhaustive direct receive patterns
        for (int c = 0; c < 3; c++)
            for (int v = 0; v < 16; v++)
                word(codes[(c == 0) ? 0 : c + 1], 4'(15 - v), 1'b0);

        // R9: code changed mid-word leaves the current word at full rate
        word(2'b11, 4'h0, 1'b1);
        rate_mode = 2'b11;
        tx_nibble = 4'b0101;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                rate_mode = 2'b01;
                if (prev_valid) chk("R8", rx_nibble, prev_exp);
            end
            chk("R9 mid-word", {3'b0, tx_serial}, {3'b0, exp_tx(2'b11, 4'b0101, k)});
        end
        prev_exp = 4'b0101;
        prev_tag = "R9";
        word(2'b01, 4'b0110, 1'b1);
        word(2'b01, 4'b0001, 1'b1);

        // R10: lock drop length and the equivalent full-rate codes
        for (int i = 0; i < L + 1; i++) word(2'b01, 4'h1, 1'b1);
        chk("R10 locked before", {3'b0, locked}, 4'h1);
        low_cnt = 0;
        for (int i = 0; i < L + 2; i++) word(2'b11, 4'(i), 1'b1);
        chk("R10 drop length", 4'(low_cnt), 4'(4 * L));
        low_cnt = 0;
        for (int i = 0; i < 4; i++) word((i % 2 == 0) ? 2'b00 : 2'b11, 4'(i + 3), 1'b1);
        chk("R10 no drop 00/11", 4'(low_cnt), 4'h0);
        word(2'b11, 4'h0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule